// File: doc/BRIEF.md
# Clock Policy Mask Controller

This block holds one clock-enable mask per power policy and drives a vector of clock enables from the mask of whichever policy is currently active. Each clock owns one bit position, and that position is the same in every policy's mask. A clock runs under the active policy only when its bit in that policy's mask is set.

Software reaches the block through a small word-addressed read/write bus. Writes are accepted only after a password has been written to the access register at word 0. Masks may only be edited while the policy engine is halted for configuration. Edits land in a staged copy of the masks. A go command carrying one of two mode bits copies the staged masks into the live set and restarts the engine. Clock enables change only at that copy point. A mask write attempted while the engine runs is dropped and raises a sticky error flag.

Top module: `clk_policy_ctl`

## Requirements
- R1: After reset the write-enable flag, the halt bit, the go field and the error flag all read 0, and every staged and live mask reads all-ones, so every clock enable is 1.
- R2: A write to word 0 whose bits 31:8 equal the PASSWORD parameter loads bit 0 into the write-enable flag. A write with any other value in bits 31:8 leaves the flag unchanged. Word 0 reads the flag in bit 0 and zeros elsewhere.
- R3: While the write-enable flag is 0, writes to every word other than 0 have no effect. This covers the halt bit, the masks, the go field and the error flag. Unused words read 0.
- R4: Word 1 bit 0 is the halt (configuration-enable) bit. It is writable when unlocked and readable at any time.
- R5: An unlocked write to word 4+p (p below NUM_POL) while halted stores bits NUM_CLK-1:0 into the staged mask of policy p. Reads of that word return it zero-extended. The clock enables do not change.
- R6: An unlocked mask write while the engine runs (halt bit 0) is dropped and sets the error flag at word 3 bit 0. The flag stays set until an unlocked write to word 3 with bit 0 set clears it.
- R7: An unlocked write to word 2 with bit 0 (go) set and bit 1 or bit 2 (the two mode bits) set is held in word 2 bits 2:0. On the next clock edge the live masks take the staged values and the halt bit clears. One edge after that, word 2 reads 0 again.
- R8: A write to word 2 that lacks the go bit, or that lacks both mode bits, copies nothing and leaves word 2 reading 0.
- R9: Clock enable i equals bit i of the live mask of the policy named by pol_sel. A pol_sel value of NUM_POL or above gives all enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pol_sel | input | $clog2(NUM_POL)+1 | Index of the active policy |
| clk_en | output | NUM_CLK | Clock enables from the live mask of the active policy |

## Verification
The bench targets the lock boundary: near-miss passwords, and writes made while locked to the halt, mask, go and status words. A design that leaked a locked write would show a changed halt bit, mask or error flag on readback.

It also targets mask writes made while the engine runs. A design that let these through would show a changed staged mask, or a missing error flag.

Go commands are checked at each cycle around the copy. The enables must not move before the copy edge, the go bits must still read set in the copy cycle, and they must read 0 one edge later. Go commands with a missing mode bit and out-of-range policy indices are also exercised, to catch a copy that fires without a mode bit and an enable vector that aliases onto a real policy.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
   // Word offsets of the register map.
   localparam int OFS_ACCESS = 0;
   localparam int OFS_HALT   = 1;
   localparam int OFS_GO     = 2;
   localparam int OFS_STAT   = 3;
   localparam int OFS_MASK0  = 4;

   // Go command field, go in bit 0.
   typedef struct packed {
      logic ac;
      logic atl;
      logic go;
   } go_cmd_t;
endpackage

// File: rtl/cpc_unlock.sv
module cpc_unlock #(
   parameter logic [23:0] PASSWORD = 24'h5EC12A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_wr,
   input  logic [31:0] wdata,
   output logic        open
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (acc_wr && (wdata[31:8] == PASSWORD))
         open_q <= wdata[0];
   end

   assign open = open_q;
endmodule

// File: rtl/cpc_engine.sv
module cpc_engine
   import cpc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    halt_wr,
   input  logic    halt_val,
   input  logic    go_wr,
   input  go_cmd_t go_in,
   input  logic    err_clr,
   input  logic    mask_try,
   output logic    halted,
   output go_cmd_t go_q,
   output logic    copy_fire,
   output logic    err,
   output logic    mask_ok
);
   logic    halted_q;
   logic    copied_q;
   logic    err_q;
   go_cmd_t cmd_q;
   logic    go_ok;

   assign go_ok     = go_wr && go_in.go && (go_in.atl || go_in.ac) && (cmd_q == '0);
   assign copy_fire = (cmd_q != '0) && !copied_q;
   assign mask_ok   = mask_try && halted_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         copied_q <= 1'b0;
         err_q    <= 1'b0;
         cmd_q    <= '0;
      end else begin
         if (copy_fire) begin
            halted_q <= 1'b0;
            copied_q <= 1'b1;
         end else if (copied_q) begin
            cmd_q    <= '0;
            copied_q <= 1'b0;
         end else if (go_ok) begin
            cmd_q    <= go_in;
         end
         if (halt_wr && !copy_fire)
            halted_q <= halt_val;
         if (mask_try && !halted_q)
            err_q <= 1'b1;
         else if (err_clr)
            err_q <= 1'b0;
      end
   end

   assign halted = halted_q;
   assign go_q   = cmd_q;
   assign err    = err_q;
endmodule

// File: rtl/cpc_mask_bank.sv
module cpc_mask_bank #(
   parameter int NUM_POL = 4,
   parameter int NUM_CLK = 8,
   localparam int IDX_W  = $clog2(NUM_POL),
   localparam int POL_W  = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [NUM_CLK-1:0] wr_data,
   input  logic               copy,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [NUM_CLK-1:0] rd_data,
   input  logic [POL_W-1:0]   pol_sel,
   output logic [NUM_CLK-1:0] clk_en
);
   logic [NUM_CLK-1:0] stage_v [NUM_POL];
   logic [NUM_CLK-1:0] live_v  [NUM_POL];

   for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
      logic [NUM_CLK-1:0] stage_q;
      logic [NUM_CLK-1:0] live_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '1;
            live_q  <= '1;
         end else begin
            if (wr_en && (wr_idx == IDX_W'(p)))
               stage_q <= wr_data;
            if (copy)
               live_q <= stage_q;
         end
      end

      assign stage_v[p] = stage_q;
      assign live_v[p]  = live_q;
   end

   assign rd_data = stage_v[rd_idx];

   always_comb begin
      clk_en = '0;
      if (int'(pol_sel) < NUM_POL)
         clk_en = live_v[pol_sel[IDX_W-1:0]];
   end
endmodule

// File: rtl/clk_policy_ctl.sv
module clk_policy_ctl
   import cpc_pkg::*;
#(
   parameter int          NUM_POL  = 4,
   parameter int          NUM_CLK  = 8,
   parameter int          ADDR_W   = 4,
   parameter logic [23:0] PASSWORD = 24'h5EC12A,
   localparam int         POL_W    = $clog2(NUM_POL) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [POL_W-1:0]   pol_sel,
   output logic [NUM_CLK-1:0] clk_en
);
   localparam int IDX_W    = $clog2(NUM_POL);
   localparam int MASK_END = OFS_MASK0 + NUM_POL;

   initial begin
      assert (NUM_CLK >= 1 && NUM_CLK <= 32) else $fatal(1, "NUM_CLK out of range");
      assert (NUM_POL >= 2) else $fatal(1, "NUM_POL below 2");
      assert (MASK_END <= (1 << ADDR_W)) else $fatal(1, "ADDR_W too small");
   end

   logic             wr, acc_wr, gated_wr;
   logic             wr_open, halted, err_flag, copy_fire, mask_try, mask_ok;
   logic             mask_hit;
   logic [IDX_W-1:0] mask_idx;
   logic [NUM_CLK-1:0] rd_mask;
   go_cmd_t          go_q;

   assign wr       = bus_sel && bus_we;
   assign acc_wr   = wr && (int'(bus_addr) == OFS_ACCESS);
   assign gated_wr = wr && wr_open && !acc_wr;
   assign mask_hit = (int'(bus_addr) >= OFS_MASK0) && (int'(bus_addr) < MASK_END);
   assign mask_idx = IDX_W'(int'(bus_addr) - OFS_MASK0);
   assign mask_try = gated_wr && mask_hit;

   cpc_unlock #(.PASSWORD(PASSWORD)) u_unlock (
      .clk   (clk),
      .rst_n (rst_n),
      .acc_wr(acc_wr),
      .wdata (bus_wdata),
      .open  (wr_open)
   );

   cpc_engine u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .halt_wr  (gated_wr && (int'(bus_addr) == OFS_HALT)),
      .halt_val (bus_wdata[0]),
      .go_wr    (gated_wr && (int'(bus_addr) == OFS_GO)),
      .go_in    (go_cmd_t'(bus_wdata[2:0])),
      .err_clr  (gated_wr && (int'(bus_addr) == OFS_STAT) && bus_wdata[0]),
      .mask_try (mask_try),
      .halted   (halted),
      .go_q     (go_q),
      .copy_fire(copy_fire),
      .err      (err_flag),
      .mask_ok  (mask_ok)
   );

   cpc_mask_bank #(.NUM_POL(NUM_POL), .NUM_CLK(NUM_CLK)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mask_ok),
      .wr_idx (mask_idx),
      .wr_data(bus_wdata[NUM_CLK-1:0]),
      .copy   (copy_fire),
      .rd_idx (mask_idx),
      .rd_data(rd_mask),
      .pol_sel(pol_sel),
      .clk_en (clk_en)
   );

   always_comb begin
      bus_rdata = '0;
      if (int'(bus_addr) == OFS_ACCESS)
         bus_rdata[0] = wr_open;
      else if (int'(bus_addr) == OFS_HALT)
         bus_rdata[0] = halted;
      else if (int'(bus_addr) == OFS_GO)
         bus_rdata[2:0] = go_q;
      else if (int'(bus_addr) == OFS_STAT)
         bus_rdata[0] = err_flag;
      else if (mask_hit)
         bus_rdata[NUM_CLK-1:0] = rd_mask;
   end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
   parameter int          NUM_POL  = 4,
   parameter int          NUM_CLK  = 8,
   parameter int          ADDR_W   = 4,
   parameter logic [23:0] PASSWORD = 24'h5EC12A,
   localparam int         POL_W    = $clog2(NUM_POL) + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [POL_W-1:0]   pol_sel,
   input logic [NUM_CLK-1:0] clk_en,
   input logic               wr_open,
   input logic               halted,
   input logic               err_flag,
   input logic               copy_fire,
   input logic               mask_try
);
   p_bad_pw_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == '0 && bus_wdata[31:8] != PASSWORD) |=> $stable(wr_open));

   p_locked_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !wr_open && bus_addr != '0 && !copy_fire)
      |=> ($stable(halted) && $stable(err_flag)));

   p_run_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_try && !halted) |=> err_flag);

   p_copy_resumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      copy_fire |=> !halted);

   p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(pol_sel) && !$past(copy_fire)) |-> $stable(clk_en));
endmodule

bind clk_policy_ctl cpc_checker #(
   .NUM_POL(NUM_POL), .NUM_CLK(NUM_CLK), .ADDR_W(ADDR_W), .PASSWORD(PASSWORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pol_sel(pol_sel),
   .clk_en(clk_en), .wr_open(wr_open), .halted(halted),
   .err_flag(err_flag), .copy_fire(copy_fire), .mask_try(mask_try)
);

// File: tb/clk_policy_ctl_bench.sv
module clk_policy_ctl_bench;
   localparam int          CLK_PERIOD = 10;
   localparam int          NP  = 4;
   localparam int          NC  = 8;
   localparam int          AW  = 4;
   localparam int          PLW = $clog2(NP) + 1;
   localparam logic [23:0] PW  = 24'h3D_71B4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [PLW-1:0] pol_sel = '0;
   logic [NC-1:0] clk_en;

   clk_policy_ctl #(.NUM_POL(NP), .NUM_CLK(NC), .ADDR_W(AW), .PASSWORD(PW)) u_clk_policy_ctl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pol_sel(pol_sel), .clk_en(clk_en)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0, fails = 0;
   bit m_open = 0, m_halt = 0, m_err = 0;
   logic [NC-1:0] m_stage [NP];
   logic [NC-1:0] m_live  [NP];

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [NC-1:0] exp_en();
      if (int'(pol_sel) < NP) return m_live[pol_sel[PLW-2:0]];
      return '0;
   endfunction

   function automatic logic [31:0] exp_rd(int a);
      if (a == 0) return {31'b0, m_open};
      if (a == 1) return {31'b0, m_halt};
      if (a == 2) return 32'b0;
      if (a == 3) return {31'b0, m_err};
      if (a >= 4 && a < 4 + NP) return {{(32 - NC){1'b0}}, m_stage[a - 4]};
      return 32'b0;
   endfunction

   function automatic string req_of(int a);
      if (a == 0) return "R2";
      if (a == 1) return "R4";
      if (a == 2) return "R8";
      if (a == 3) return "R6";
      if (a >= 4 && a < 4 + NP) return "R5";
      return "R3";
   endfunction

   task automatic rd_chk(int a, string req);
      @(negedge clk);
      bus_addr = AW'(a);
      #1 chk(req, bus_rdata, exp_rd(a));
   endtask

   task automatic bus_write(int a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic do_write(int a, logic [31:0] d);
      bit go_ok = 0;
      logic [NC-1:0] old_en = exp_en();
      bus_write(a, d);
      if (a == 0) begin
         if (d[31:8] == PW) m_open = d[0];
      end else if (m_open) begin
         if (a == 1) m_halt = d[0];
         else if (a == 2) go_ok = d[0] && (d[1] || d[2]);
         else if (a == 3) begin if (d[0]) m_err = 0; end
         else if (a >= 4 && a < 4 + NP) begin
            if (m_halt) m_stage[a - 4] = d[NC-1:0];
            else m_err = 1;
         end
      end
      if (go_ok) begin
         bus_addr = 2; #1;
         chk("R7 go bits held", bus_rdata, {29'b0, d[2:0]});
         chk("R7 enables unchanged before copy", {24'b0, clk_en}, {24'b0, old_en});
         @(negedge clk);
         for (int p = 0; p < NP; p++) m_live[p] = m_stage[p];
         m_halt = 0;
         #1 chk("R7 enables after copy", {24'b0, clk_en}, {24'b0, exp_en()});
         chk("R7 go bits still set in copy cycle", bus_rdata, {29'b0, d[2:0]});
         bus_addr = 1; #1 chk("R7 halt cleared", bus_rdata, 32'b0);
         rd_chk(2, "R7 go bits self-cleared");
      end else if (a == 2) begin
         rd_chk(2, "R8 go field stays zero");
      end
      #1 chk("R9 enables", {24'b0, clk_en}, {24'b0, exp_en()});
      if (!go_ok) rd_chk(a, req_of(a));
   endtask

   task automatic set_pol(int v);
      @(negedge clk);
      pol_sel = PLW'(v);
      #1 chk("R9 policy select", {24'b0, clk_en}, {24'b0, exp_en()});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (all R tags): got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd51873));
      for (int p = 0; p < NP; p++) begin m_stage[p] = '1; m_live[p] = '1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 8; a++) rd_chk(a, "R1 reset read");
      chk("R1 reset enables", {24'b0, clk_en}, 32'h0000_00FF);
      // R3 locked writes
      do_write(1, 32'h1);
      do_write(4, 32'h0);
      do_write(3, 32'h1);
      // R2 password handling
      do_write(0, {PW ^ 24'h000100, 8'h01});
      do_write(0, {PW, 8'h01});
      chk("R2 unlocked", bus_rdata, 32'h1);
      // R6 write while running
      do_write(4, 32'h0F);
      rd_chk(3, "R6 error set");
      // R4 and R5
      do_write(1, 32'h1);
      do_write(5, 32'h3C);
      set_pol(1);
      chk("R5 enables not yet changed", {24'b0, clk_en}, 32'hFF);
      // R8 malformed go
      do_write(2, 32'h1);
      do_write(2, 32'h6);
      // R7 go with first mode bit
      do_write(2, 32'h3);
      chk("R7 policy 1 live", {24'b0, clk_en}, 32'h3C);
      // R9 out-of-range policy
      set_pol(5);
      chk("R9 out of range gives zero", {24'b0, clk_en}, 32'h0);
      set_pol(3);
      // R6 clear
      do_write(3, 32'h1);
      rd_chk(3, "R6 error cleared");
      // R7 go with second mode bit
      do_write(1, 32'h1);
      do_write(7, 32'hA5);
      do_write(2, 32'h5);
      chk("R7 policy 3 live", {24'b0, clk_en}, 32'hA5);
      // Random mix
      for (int i = 0; i < 400; i++) begin
         int r = $urandom_range(0, 99);
         if (r < 10)      do_write(0, {PW, 8'h01});
         else if (r < 14) do_write(0, {PW, 8'h00});
         else if (r < 18) do_write(0, {PW ^ (24'h1 << $urandom_range(0, 23)), 8'h01});
         else if (r < 30) do_write(1, {31'b0, 1'($urandom_range(0, 1))});
         else if (r < 60) do_write(4 + $urandom_range(0, NP - 1), $urandom);
         else if (r < 72) do_write(2, {29'b0, 3'($urandom_range(0, 7))});
         else if (r < 78) do_write(3, {31'b0, 1'($urandom_range(0, 1))});
         else if (r < 88) set_pol($urandom_range(0, (1 << PLW) - 1));
         else             do_write($urandom_range(4 + NP, (1 << AW) - 1), $urandom);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule